// File: doc/BRIEF.md
# Transaction-to-Flit Packetizer

This block sits at the source side of an on-chip packet network. It takes one request at a time from an initiator. A request holds a destination, a packet tag, a service class, an operation (read or write) and a beat count. The block turns each request into an ordered run of flits for the first router. A header flit carries the control fields. For a write, payload flits follow, one per data beat, and the last flit of every packet is marked so that routers can free the resources they hold for it.

Write data arrives on a separate beat channel. The block takes a beat only while it is building the payload part of a packet and holds a credit. A credit counter stands for the free slots in the router's input buffer. It allows a flit onto the link only when a slot is known to be free, so no flit is ever dropped or overwritten. Requests are served strictly one after another, so packets leave in the order the block accepted them.

Top module: `flit_packetizer`

## Requirements
- R1: A header flit uses this layout, counting from the MSB of the flit: 2-bit kind, then 4-bit destination, 4-bit packet tag, 2-bit class, and 2-bit operation (00 read, 01 write). All remaining low bits are zero. The kind is 00 for a header that is followed by payload.
- R2: A payload flit carries kind 01 in its top two bits. The data beat fills all of the remaining low bits unchanged.
- R3: The credit count resets to CREDIT_DEPTH. Each flit sent lowers it by one and each credit_in pulse raises it by one. flit_valid is never high while the count is zero.
- R4: If a credit returns in the same cycle that a flit is sent, the count stays the same, so sending can continue without a gap.
- R5: A read request gives exactly one flit of kind 11 (header and end together), and req_len is ignored.
- R6: A write with N>0 beats gives one header flit and then N payload flits. The last payload flit is marked with kind 10 instead of 01.
- R7: req_ready drops in the cycle after a request is accepted. It stays low until the cycle after the end-marked flit of that packet has been sent.
- R8: Flits of one packet leave in sequence, and packets leave in the order their requests were accepted.
- R9: A write with zero beats gives one flit of kind 11 with operation 01.
- R10: dat_ready is high only while a payload flit is due and a credit is held. A beat offered at any other time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_dest | input | 4 | Destination node |
| req_pid | input | 4 | Packet tag |
| req_qos | input | 2 | Service class |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Number of write beats |
| dat_valid | input | 1 | Write beat present |
| dat_ready | output | 1 | Write beat taken this cycle if valid |
| dat_bits | input | FLIT_W-2 | Write beat |
| flit_valid | output | 1 | Flit on the link this cycle |
| flit_data | output | FLIT_W | Flit contents |
| credit_in | input | 1 | One buffer slot freed downstream |

## Verification
The hardest case to reach is a long write that runs out of credits partway through its payload. The credit must then return in the same cycle a beat is ready, and the beat source must hold its data while the block waits. The stimulus sends writes of fifteen beats against a four-slot budget. Credits come back only every fifth cycle in one phase, while in another phase beats arrive only every third cycle. A reference model that tracks credits and queued flits every cycle predicts each stall and restart exactly.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int KIND_W = 2;
  localparam int DEST_W = 4;
  localparam int PID_W  = 4;
  localparam int QOS_W  = 2;
  localparam int OP_W   = 2;
  localparam int HDR_W  = DEST_W + PID_W + QOS_W + OP_W;

  typedef enum logic [KIND_W-1:0] {
    FK_HEAD   = 2'b00,
    FK_BODY   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01
  } op_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [PID_W-1:0]  pid;
    logic [QOS_W-1:0]  qos;
    op_e               op;
  } hdr_t;
endpackage

// File: rtl/pkt_credit_ctr.sv
module pkt_credit_ctr #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic          avail,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = take ^ give;
    cnt_d  = cnt_q;
    if (take && !give)      cnt_d = cnt_q - CW'(1);
    else if (give && !take) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(DEPTH);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign avail = (cnt_q != '0);
  assign count = cnt_q;
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  hdr_t             req_hdr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             credit_ok,
  input  logic             dat_valid,
  output logic             dat_ready,
  output logic             send,
  output flit_kind_e       kind,
  output hdr_t             hdr_q
);
  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_BODY} state_e;

  state_e           state_q, state_d;
  logic [LEN_W-1:0] beats_q, beats_d;
  logic             beats_en, accept, head_fire, body_fire;

  always_comb begin
    req_ready = (state_q == S_IDLE);
    accept    = req_valid && req_ready;
    head_fire = (state_q == S_HEAD) && credit_ok;
    dat_ready = (state_q == S_BODY) && credit_ok;
    body_fire = dat_ready && dat_valid;
    send      = head_fire || body_fire;
  end

  always_comb begin
    kind = FK_HEAD;
    if (state_q == S_HEAD)      kind = (beats_q == '0) ? FK_SINGLE : FK_HEAD;
    else if (state_q == S_BODY) kind = (beats_q == LEN_W'(1)) ? FK_TAIL : FK_BODY;
  end

  always_comb begin
    state_d  = state_q;
    beats_d  = beats_q;
    beats_en = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d  = S_HEAD;
        beats_en = 1'b1;
        beats_d  = (req_hdr.op == OP_WRITE) ? req_len : '0;
      end
      S_HEAD: if (head_fire) state_d = (beats_q == '0) ? S_IDLE : S_BODY;
      S_BODY: if (body_fire) begin
        beats_en = 1'b1;
        beats_d  = beats_q - LEN_W'(1);
        if (beats_q == LEN_W'(1)) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beats_q <= '0;
    else if (beats_en) beats_q <= beats_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdr_q <= '0;
    else if (accept) hdr_q <= req_hdr;
  end
endmodule

// File: rtl/pkt_flit_fmt.sv
module pkt_flit_fmt
  import pkt_pkg::*;
#(
  parameter int FLIT_W = 32,
  localparam int DATA_W = FLIT_W - KIND_W,
  localparam int RSV_W  = FLIT_W - KIND_W - HDR_W
) (
  input  flit_kind_e        kind,
  input  hdr_t              hdr,
  input  logic [DATA_W-1:0] beat,
  output logic [FLIT_W-1:0] flit
);
  generate
    if (RSV_W > 0) begin : g_rsv
      always_comb begin
        if (kind == FK_HEAD || kind == FK_SINGLE) flit = {kind, hdr, {RSV_W{1'b0}}};
        else                                       flit = {kind, beat};
      end
    end else begin : g_tight
      always_comb begin
        if (kind == FK_HEAD || kind == FK_SINGLE) flit = {kind, hdr};
        else                                       flit = {kind, beat};
      end
    end
  endgenerate
endmodule

// File: rtl/flit_packetizer.sv
module flit_packetizer
  import pkt_pkg::*;
#(
  parameter int FLIT_W       = 32,
  parameter int LEN_W        = 4,
  parameter int CREDIT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_dest,
  input  logic [3:0]        req_pid,
  input  logic [1:0]        req_qos,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [FLIT_W-3:0] dat_bits,
  output logic              flit_valid,
  output logic [FLIT_W-1:0] flit_data,
  input  logic              credit_in
);
  localparam int CW = $clog2(CREDIT_DEPTH + 1);

  hdr_t          in_hdr, cur_hdr;
  flit_kind_e    cur_kind;
  logic          credit_ok, send;
  logic [CW-1:0] credit_cnt;

  always_comb begin
    in_hdr.dest = req_dest;
    in_hdr.pid  = req_pid;
    in_hdr.qos  = req_qos;
    in_hdr.op   = req_write ? OP_WRITE : OP_READ;
  end

  pkt_credit_ctr #(.DEPTH(CREDIT_DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .take(send), .give(credit_in),
    .avail(credit_ok), .count(credit_cnt)
  );

  pkt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hdr(in_hdr), .req_len(req_len), .credit_ok(credit_ok),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .send(send),
    .kind(cur_kind), .hdr_q(cur_hdr)
  );

  pkt_flit_fmt #(.FLIT_W(FLIT_W)) u_fmt (
    .kind(cur_kind), .hdr(cur_hdr), .beat(dat_bits), .flit(flit_data)
  );

  assign flit_valid = send;
endmodule

// File: rtl/pkt_checker.sv
module pkt_checker #(
  parameter int FLIT_W       = 32,
  parameter int CREDIT_DEPTH = 4,
  localparam int CW = $clog2(CREDIT_DEPTH + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dat_ready,
  input logic              flit_valid,
  input logic [FLIT_W-1:0] flit_data,
  input logic              credit_in
);
  logic [CW-1:0] seen_cred;
  logic          in_pkt;
  logic [1:0]    kind;

  assign kind = flit_data[FLIT_W-1 -: 2];

  // Port-side credit tracking; simultaneous send and return cancel (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_cred <= CW'(CREDIT_DEPTH);
    else        seen_cred <= seen_cred - CW'(flit_valid) + CW'(credit_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (flit_valid) in_pkt <= (kind == 2'b00) || (kind == 2'b01);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> seen_cred != '0);

  p_ready_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_head_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !in_pkt) |-> (kind == 2'b00 || kind == 2'b11));

  p_body_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && in_pkt) |-> (kind == 2'b01 || kind == 2'b10));

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && (kind == 2'b00 || kind == 2'b11)) |-> flit_data[FLIT_W-17:0] == '0);

  p_beat_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (in_pkt && seen_cred != '0));

  p_idle_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt |-> !req_ready);
endmodule

bind flit_packetizer pkt_checker #(.FLIT_W(FLIT_W), .CREDIT_DEPTH(CREDIT_DEPTH)) u_pkt_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dat_ready(dat_ready), .flit_valid(flit_valid), .flit_data(flit_data),
  .credit_in(credit_in)
);

// File: tb/test_flit_packetizer.sv
module test_flit_packetizer;
  localparam int FW = 32;
  localparam int LW = 4;
  localparam int DEPTH = 4;
  localparam int LIMIT = 20000;

  typedef struct {
    int dest; int pid; int qos; int wr; int len;
  } req_s;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, dat_valid, credit_in;
  logic req_ready, dat_ready, flit_valid;
  logic [3:0] req_dest, req_pid;
  logic [1:0] req_qos;
  logic [LW-1:0] req_len;
  logic [FW-3:0] dat_bits;
  logic [FW-1:0] flit_data;

  always #5 clk = ~clk;

  flit_packetizer #(.FLIT_W(FW), .LEN_W(LW), .CREDIT_DEPTH(DEPTH)) i_flit_packetizer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_pid(req_pid), .req_qos(req_qos),
    .req_write(req_write), .req_len(req_len), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_bits(dat_bits), .flit_valid(flit_valid),
    .flit_data(flit_data), .credit_in(credit_in)
  );

  req_s          pend[$];
  logic [FW-1:0] expq[$];
  logic [FW-3:0] dq[$];
  int credits, cyc, checks, fails;
  int ret_per, dgap, rgap;
  bit hung;

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [FW-3:0] beat_val(input int pid, input int b);
    return (FW-2)'(32'h15A5_0000 + pid * 4099 + b * 263);
  endfunction

  task automatic add_req(input int dest, input int pid, input int qos, input int wr, input int len);
    req_s r;
    r.dest = dest; r.pid = pid; r.qos = qos; r.wr = wr; r.len = len;
    pend.push_back(r);
  endtask

  task automatic load_flits(input req_s r);
    int nb;
    logic [FW-1:0] f;
    nb = r.wr ? r.len : 0;
    f = ((nb == 0) ? 32'h3 : 32'h0) << 30;
    f = f | (32'(r.dest) << 26) | (32'(r.pid) << 22) | (32'(r.qos) << 20) | (32'(r.wr) << 18);
    expq.push_back(f);
    for (int b = 0; b < nb; b++) begin
      logic [FW-3:0] v;
      v = beat_val(r.pid, b);
      expq.push_back((((b == nb - 1) ? 32'h2 : 32'h1) << 30) | 32'(v));
      dq.push_back(v);
    end
  endtask

  task automatic one_cycle();
    bit acc, snd, ret;
    bit exp_v, exp_dr, front_hdr;
    req_s r;
    // drive inputs just after the rising edge
    ret = (credits < DEPTH) && (cyc % ret_per == 0);
    credit_in = ret;
    req_valid = (pend.size() > 0) && (rgap == 0 || cyc % rgap != 0);
    if (pend.size() > 0) begin
      r = pend[0];
      req_dest = 4'(r.dest); req_pid = 4'(r.pid); req_qos = 2'(r.qos);
      req_write = r.wr[0];
      req_len = r.wr ? LW'(r.len) : LW'(7);
    end
    dat_valid = (dq.size() > 0) && (dgap == 0 || cyc % dgap == 0);
    dat_bits = (dq.size() > 0) ? dq[0] : '0;
    @(negedge clk);
    front_hdr = (expq.size() > 0) && (expq[0][31:30] == 2'b00 || expq[0][31:30] == 2'b11);
    exp_v  = (expq.size() > 0) && (credits > 0) && (front_hdr || dat_valid);
    exp_dr = (expq.size() > 0) && !front_hdr && (credits > 0);
    chk(req_ready == (expq.size() == 0), "R7 req_ready", 32'(req_ready), 32'(expq.size() == 0));
    chk(dat_ready == exp_dr, "R10 dat_ready", 32'(dat_ready), 32'(exp_dr));
    chk(flit_valid == exp_v, "R3 R4 flit_valid", 32'(flit_valid), 32'(exp_v));
    if (exp_v && flit_valid) begin
      case (expq[0][31:30])
        2'b00:   chk(flit_data == expq[0], "R1 R8 header flit", flit_data, expq[0]);
        2'b01:   chk(flit_data == expq[0], "R2 R8 payload flit", flit_data, expq[0]);
        2'b10:   chk(flit_data == expq[0], "R6 end-marked payload flit", flit_data, expq[0]);
        default: chk(flit_data == expq[0], "R5 R9 single flit", flit_data, expq[0]);
      endcase
    end
    acc = req_valid && req_ready;
    snd = flit_valid;
    @(posedge clk);
    #1;
    cyc++;
    if (acc) begin
      load_flits(pend[0]);
      void'(pend.pop_front());
    end
    if (snd && expq.size() > 0) begin
      if (expq[0][31:30] == 2'b01 || expq[0][31:30] == 2'b10) void'(dq.pop_front());
      void'(expq.pop_front());
    end
    credits = credits - int'(snd) + int'(ret);
  endtask

  task automatic drain();
    while ((pend.size() > 0 || expq.size() > 0 || credits < DEPTH) && cyc < LIMIT) one_cycle();
    if (cyc >= LIMIT && !hung) begin
      hung = 1'b1;
      chk(1'b0, "watchdog", 32'(cyc), 32'(LIMIT));
    end
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 1; credits = DEPTH; hung = 1'b0;
    ret_per = 1; dgap = 0; rgap = 0;
    rst_n = 1'b0; req_valid = 1'b0; dat_valid = 1'b0; credit_in = 1'b0;
    req_dest = '0; req_pid = '0; req_qos = '0; req_write = 1'b0; req_len = '0; dat_bits = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 reset req_ready", 32'(req_ready), 32'h1);
    chk(flit_valid == 1'b0, "R3 reset flit_valid", 32'(flit_valid), 32'h0);
    chk(dat_ready == 1'b0, "R10 reset dat_ready", 32'(dat_ready), 32'h0);
    @(posedge clk);
    #1;

    // phase 1: ample credits, mixed packets (R1 R5 R6 R9)
    add_req(3, 1, 2, 0, 0);
    add_req(9, 2, 1, 1, 2);
    add_req(15, 3, 3, 1, 0);
    add_req(0, 4, 0, 0, 0);
    add_req(6, 5, 2, 1, 1);
    drain();

    // phase 2: long writes against a scarce credit return (R3 R4)
    ret_per = 5;
    add_req(12, 6, 3, 1, 15);
    add_req(1, 7, 0, 0, 0);
    add_req(10, 8, 1, 1, 15);
    drain();

    // phase 3: sparse beats and gapped requests (R10 R8)
    ret_per = 2; dgap = 3; rgap = 2;
    add_req(5, 9, 2, 1, 4);
    add_req(7, 10, 1, 1, 3);
    add_req(2, 11, 0, 0, 0);
    add_req(14, 12, 3, 1, 0);
    drain();

    // phase 4: credit back every cycle, continuous payload (R4)
    ret_per = 1; dgap = 0; rgap = 0;
    add_req(8, 13, 1, 1, 15);
    add_req(4, 14, 2, 1, 9);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule